// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits in front of one or two SDRAM devices and turns short host command writes into the pin-level command sequence that brings the devices out of power-up. The host writes a command mode, a two-bit device target mask, a refresh repeat field and a mode-register value in a single cycle. The sequencer drives the matching command onto the shared RAS_n/CAS_n/WE_n/BA/address pins and the per-device chip selects. It then holds the targeted devices busy until the command's minimum spacing has elapsed.

The expected host flow is: wait for the power-up delay to finish, enable the clock, wait out the stabilization time, precharge all banks, run a burst of auto-refresh cycles, and load the mode register. A typical mode value is burst length 8, sequential bursts and CAS latency 2, which is 13'h023. Before each write the host polls the per-device busy status. A write that arrives while either device is busy is dropped and recorded in a sticky error flag. One write can address both devices, and both then receive the same command in the same cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, both `dev_busy` bits stay high for exactly PWRUP_CYC clock cycles. During that time `sd_cke` is 2'b00 and both `sd_cs_n` bits are high.
- R2: Mode 3'd1 (clock enable) sets the `sd_cke` bit of each targeted device in the cycle after the write. That bit then stays set until reset. No chip select is asserted, and the targeted devices read busy for STAB_CYC cycles.
- R3: Mode 3'd2 (precharge all) produces one command cycle. In that cycle the targeted chip selects are low, RAS_n=0, CAS_n=1, WE_n=0, address bit 10 is 1, all other address bits are 0 and BA=0. The targeted devices read busy for T_RP cycles.
- R4: Mode 3'd3 (auto-refresh) with field `cmd_nrfs`=n produces n+1 refresh commands (RAS_n=0, CAS_n=0, WE_n=1, address 0). Consecutive refresh commands are exactly T_RC cycles apart, and busy lasts (n+1)*T_RC cycles.
- R5: Mode 3'd4 (load mode) produces one command cycle with RAS_n=CAS_n=WE_n=0, BA=0 and the address equal to `cmd_mval`. The targeted devices read busy for T_MRD cycles.
- R6: Bit 0 of `cmd_target` selects device 0 (`sd_cs_n[0]`, `dev_busy[0]`) and bit 1 selects device 1. With both bits set, both chip selects fall in the same cycle. A device that is not targeted stays not-busy and its chip select stays high.
- R7: `dev_busy` of a targeted device rises in the cycle after an accepted write, which is also the cycle of the first pin command. It returns low once the command's spacing has elapsed, and low means normal.
- R8: A write of a known mode with a non-zero target while either `dev_busy` bit is high is ignored: no pin activity and no change to `sd_cke`. It sets `cmd_err`, which stays set until reset.
- R9: A write with target 2'b00, with mode 3'd0, or with modes 3'd5 to 3'd7 is ignored. It produces no pin command, no busy and no error.
- R10: A chip select is never low in two consecutive cycles, and it is low only while its device reads busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe, one cycle |
| cmd_mode | input | 3 | Command mode: 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode |
| cmd_target | input | 2 | Device target mask, bit i selects device i |
| cmd_nrfs | input | 4 | Auto-refresh repeat field, value n gives n+1 refreshes |
| cmd_mval | input | ADDR_W | Mode-register value for load mode |
| sd_cke | output | 2 | Clock enable per device |
| sd_cs_n | output | 2 | Chip select per device, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address pins |
| dev_busy | output | 2 | Per-device status: 1 busy, 0 normal |
| cmd_err | output | 1 | Sticky flag for writes dropped while busy |

## Verification
The bench times the busy window of every command to the exact cycle. A sequencer off by one in its wait loading would shorten the refresh spacing below tRC, or release the host before the mode register has settled. The bench counts refresh commands across the full range of the repeat field, including a single refresh and sixteen. An off-by-one in the repeat count would show up as a missing or extra refresh. It sends a second write in the first cycle of a running burst, and a write during the power-up window. A design that queued or executed these would put a stray command on the pins or raise CKE early. Writes with an empty target or an unused mode must leave the error flag clear, so a design that flags every rejected write is caught.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam logic [2:0] MODE_NOP    = 3'd0;
    localparam logic [2:0] MODE_CLKEN  = 3'd1;
    localparam logic [2:0] MODE_PALL   = 3'd2;
    localparam logic [2:0] MODE_AREF   = 3'd3;
    localparam logic [2:0] MODE_LOADMR = 3'd4;

    localparam int NUM_DEV   = 2;
    localparam int NRFS_W    = 4;
    localparam int PALL_BIT  = 10;

    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_code_t;

endpackage

// File: rtl/sdram_delay_timer.sv
module sdram_delay_timer #(
    parameter int CNT_W   = 17,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_encoder.sv
module sdram_cmd_encoder
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                fire,
    input  logic [2:0]          op,
    input  logic [NUM_DEV-1:0]  tgt,
    input  logic [ADDR_W-1:0]   mval,
    output logic [NUM_DEV-1:0]  cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [1:0]          ba,
    output logic [ADDR_W-1:0]   addr
);

    pin_code_t code;
    logic      selects;

    always_comb begin
        code    = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        selects = 1'b0;
        addr    = '0;
        if (fire) begin
            case (op)
                MODE_PALL: begin
                    code           = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                    selects        = 1'b1;
                    addr[PALL_BIT] = 1'b1;
                end
                MODE_AREF: begin
                    code    = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
                    selects = 1'b1;
                end
                MODE_LOADMR: begin
                    code    = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                    selects = 1'b1;
                    addr    = mval;
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
        assign cs_n[i] = ~(selects & tgt[i]);
    end

    assign ras_n = code.ras_n;
    assign cas_n = code.cas_n;
    assign we_n  = code.we_n;
    assign ba    = 2'b00;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PWRUP_CYC = 10000,
    parameter int STAB_CYC  = 100000,
    parameter int T_RP      = 3,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_mode,
    input  logic [1:0]        cmd_target,
    input  logic [3:0]        cmd_nrfs,
    input  logic [ADDR_W-1:0] cmd_mval,
    output logic [1:0]        sd_cke,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [1:0]        dev_busy,
    output logic              cmd_err
);

    localparam int MAX_AB  = (PWRUP_CYC > STAB_CYC) ? PWRUP_CYC : STAB_CYC;
    localparam int MAX_CD  = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_CDE = (MAX_CD > T_MRD) ? MAX_CD : T_MRD;
    localparam int MAX_CYC = (MAX_AB > MAX_CDE) ? MAX_AB : MAX_CDE;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [2:0]          op;
        logic [NUM_DEV-1:0]  tgt;
        logic [NRFS_W-1:0]   rfs_left;
        logic [ADDR_W-1:0]   mval;
        logic [NUM_DEV-1:0]  cke;
        logic                err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [TMR_W-1:0] gap_m2;
    logic             mode_known;
    logic [1:0]       busy_int;

    sdram_delay_timer #(
        .CNT_W   (TMR_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        case (r_q.op)
            MODE_CLKEN: gap_m2 = TMR_W'(STAB_CYC - 2);
            MODE_PALL:  gap_m2 = TMR_W'(T_RP - 2);
            MODE_AREF:  gap_m2 = TMR_W'(T_RC - 2);
            default:    gap_m2 = TMR_W'(T_MRD - 2);
        endcase
    end

    always_comb begin
        case (r_q.st)
            ST_PWRUP:          busy_int = 2'b11;
            ST_ISSUE, ST_WAIT: busy_int = r_q.tgt;
            default:           busy_int = 2'b00;
        endcase
    end

    assign mode_known = (cmd_mode == MODE_CLKEN) || (cmd_mode == MODE_PALL) ||
                        (cmd_mode == MODE_AREF)  || (cmd_mode == MODE_LOADMR);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        case (r_q.st)
            ST_PWRUP: begin
                if (tmr_expired) r_d.st = ST_IDLE;
            end
            ST_ISSUE: begin
                tmr_load = 1'b1;
                tmr_val  = gap_m2;
                r_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    if (r_q.op == MODE_AREF && r_q.rfs_left != '0) begin
                        r_d.rfs_left = r_q.rfs_left - 1'b1;
                        r_d.st       = ST_ISSUE;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (cmd_valid && mode_known && cmd_target != 2'b00) begin
            if (busy_int != 2'b00) begin
                r_d.err = 1'b1;
            end else begin
                r_d.st       = ST_ISSUE;
                r_d.op       = cmd_mode;
                r_d.tgt      = cmd_target;
                r_d.rfs_left = cmd_nrfs;
                r_d.mval     = cmd_mval;
                if (cmd_mode == MODE_CLKEN) r_d.cke = r_q.cke | cmd_target;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_PWRUP, op: MODE_NOP, tgt: '0, rfs_left: '0,
                     mval: '0, cke: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    sdram_cmd_encoder #(
        .ADDR_W (ADDR_W)
    ) u_enc (
        .fire  (r_q.st == ST_ISSUE),
        .op    (r_q.op),
        .tgt   (r_q.tgt),
        .mval  (r_q.mval),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .ba    (sd_ba),
        .addr  (sd_addr)
    );

    assign sd_cke   = r_q.cke;
    assign dev_busy = busy_int;
    assign cmd_err  = r_q.err;

    // R1
    pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PWRUP) |-> (sd_cs_n == 2'b11 && sd_cke == 2'b00));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke != 2'b00) |=> ((sd_cke & $past(sd_cke)) == $past(sd_cke)));

    // R3
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n != 2'b11 && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[PALL_BIT]);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R10
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n != 2'b11) |=> (sd_cs_n == 2'b11));

    // R10
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sd_cs_n) & (~dev_busy)) == 2'b00);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    localparam int ADDR_W = 13;
    localparam int PWRUP  = 20;
    localparam int STAB   = 10;
    localparam int TRP    = 3;
    localparam int TRC    = 5;
    localparam int TMRD   = 2;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  tgt;
        logic [3:0]  nrfs;
        logic [12:0] mval;
        logic [4:0]  ncmd;
        logic [7:0]  nbusy;
        logic [1:0]  cke;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{3'd1, 2'b01, 4'd0,  13'h000, 5'd0,  8'(STAB),     2'b01},
        '{3'd1, 2'b10, 4'd0,  13'h000, 5'd0,  8'(STAB),     2'b11},
        '{3'd2, 2'b01, 4'd0,  13'h000, 5'd1,  8'(TRP),      2'b11},
        '{3'd2, 2'b11, 4'd0,  13'h000, 5'd1,  8'(TRP),      2'b11},
        '{3'd3, 2'b11, 4'd2,  13'h000, 5'd3,  8'(3 * TRC),  2'b11},
        '{3'd3, 2'b10, 4'd0,  13'h000, 5'd1,  8'(TRC),      2'b11},
        '{3'd3, 2'b01, 4'd15, 13'h000, 5'd16, 8'(16 * TRC), 2'b11},
        '{3'd4, 2'b11, 4'd0,  13'h023, 5'd1,  8'(TMRD),     2'b11},
        '{3'd4, 2'b10, 4'd0,  13'h1A5, 5'd1,  8'(TMRD),     2'b11}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_mode = '0;
    logic [1:0]        cmd_target = '0;
    logic [3:0]        cmd_nrfs = '0;
    logic [ADDR_W-1:0] cmd_mval = '0;
    logic [1:0]        sd_cke, sd_cs_n, sd_ba, dev_busy;
    logic              sd_ras_n, sd_cas_n, sd_we_n, cmd_err;
    logic [ADDR_W-1:0] sd_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(ADDR_W), .PWRUP_CYC(PWRUP), .STAB_CYC(STAB),
        .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_target(cmd_target), .cmd_nrfs(cmd_nrfs), .cmd_mval(cmd_mval),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .dev_busy(dev_busy),
        .cmd_err(cmd_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] m, input logic [1:0] t,
                        input logic [3:0] n, input logic [12:0] v);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_mode   = m;
        cmd_target = t;
        cmd_nrfs   = n;
        cmd_mval   = v;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_idle();
        while (dev_busy != 2'b00) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        int off = 0;
        int cmds = 0;
        int last_off = 0;
        string req;
        logic [2:0]  exp_code;
        logic [12:0] exp_addr;
        case (v.mode)
            3'd1: begin req = "R2"; exp_code = 3'b111; exp_addr = 13'h000; end
            3'd2: begin req = "R3"; exp_code = 3'b010; exp_addr = 13'h400; end
            3'd3: begin req = "R4"; exp_code = 3'b001; exp_addr = 13'h000; end
            default: begin req = "R5"; exp_code = 3'b000; exp_addr = v.mval; end
        endcase
        wait_idle();
        send(v.mode, v.tgt, v.nrfs, v.mval);
        while ((dev_busy & v.tgt) != 2'b00 && off < 1000) begin
            // R6: untargeted device stays normal
            check((dev_busy & ~v.tgt) == 2'b00, "R6", int'(dev_busy), int'(v.tgt));
            if (sd_cs_n != 2'b11) begin
                cmds++;
                last_off = off;
                check(sd_cs_n == ~v.tgt, "R6", int'(sd_cs_n), int'(~v.tgt));
                check({sd_ras_n, sd_cas_n, sd_we_n} == exp_code, req,
                      int'({sd_ras_n, sd_cas_n, sd_we_n}), int'(exp_code));
                check(sd_addr == exp_addr, req, int'(sd_addr), int'(exp_addr));
                check(sd_ba == 2'b00, req, int'(sd_ba), 0);
            end
            off++;
            @(negedge clk);
        end
        check(cmds == int'(v.ncmd), req, cmds, int'(v.ncmd));
        // R7: busy window length
        check(off == int'(v.nbusy), "R7", off, int'(v.nbusy));
        if (v.ncmd != 0)
            check(last_off == (int'(v.ncmd) - 1) * TRC, "R4", last_off,
                  (int'(v.ncmd) - 1) * TRC);
        check(sd_cke == v.cke, "R2", int'(sd_cke), int'(v.cke));
        check(cmd_err == 1'b0, "R8", int'(cmd_err), 0);
    endtask

    task automatic expect_quiet(input string req);
        for (int k = 0; k < 4; k++) begin
            check(sd_cs_n == 2'b11 && dev_busy == 2'b00, req,
                  int'({sd_cs_n, dev_busy}), 4'b1100);
            @(negedge clk);
        end
        check(cmd_err == 1'b0, req, int'(cmd_err), 0);
    endtask

    initial begin
        int pw;
        int rc;
        // reset state, R1
        repeat (2) @(negedge clk);
        check(sd_cke == 2'b00 && sd_cs_n == 2'b11 && dev_busy == 2'b11 && !cmd_err,
              "R1", int'({sd_cke, sd_cs_n, dev_busy, cmd_err}), 7'b0011110);
        rst_n = 1'b1;
        pw = 0;
        while (dev_busy == 2'b11 && pw < 1000) begin
            check(sd_cs_n == 2'b11 && sd_cke == 2'b00, "R1",
                  int'({sd_cs_n, sd_cke}), 4'b1100);
            pw++;
            @(negedge clk);
        end
        check(pw == PWRUP, "R1", pw, PWRUP);

        for (int i = 0; i < 9; i++) run_vec(VECS[i]);

        // R9: empty target, nop mode, reserved mode
        send(3'd2, 2'b00, 4'd0, 13'd0);
        expect_quiet("R9");
        send(3'd0, 2'b11, 4'd0, 13'd0);
        expect_quiet("R9");
        send(3'd6, 2'b11, 4'd0, 13'd0);
        expect_quiet("R9");

        // R8: write during a running refresh burst
        send(3'd3, 2'b11, 4'd3, 13'd0);
        cmd_valid  = 1'b1;
        cmd_mode   = 3'd4;
        cmd_target = 2'b01;
        cmd_mval   = 13'h0FF;
        rc = (sd_cs_n != 2'b11) ? 1 : 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b1, "R8", int'(cmd_err), 1);
        while (dev_busy != 2'b00) begin
            if (sd_cs_n != 2'b11) begin
                rc++;
                check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001, "R8",
                      int'({sd_ras_n, sd_cas_n, sd_we_n}), 1);
            end
            @(negedge clk);
        end
        check(rc == 4, "R8", rc, 4);
        repeat (3) @(negedge clk);
        check(cmd_err == 1'b1 && sd_cs_n == 2'b11, "R8", int'({cmd_err, sd_cs_n}), 3'b111);

        // reset clears flag and CKE, then R8 during power-up
        do_reset();
        check(cmd_err == 1'b0 && sd_cke == 2'b00 && dev_busy == 2'b11, "R1",
              int'({cmd_err, sd_cke, dev_busy}), 5'b00011);
        send(3'd1, 2'b11, 4'd0, 13'd0);
        check(cmd_err == 1'b1 && sd_cke == 2'b00, "R8", int'({cmd_err, sd_cke}), 3'b100);
        wait_idle();
        repeat (3) @(negedge clk);
        check(sd_cke == 2'b00 && dev_busy == 2'b00 && sd_cs_n == 2'b11, "R8",
              int'({sd_cke, dev_busy, sd_cs_n}), 6'b000011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule